// File: doc/BRIEF.md
# Spiking Membrane-Potential Max-Pool Stage

This block pools the output of a spiking convolution layer without storing any spike history. In every timestep the convolution core streams its feature map in raster order, one neuron per cycle. Each beat carries the neuron's signed membrane potential and the spike bit the neuron produced in that timestep. A row delay chain and a small window register array rebuild each pooling window from the stream. When a window is complete, a comparator tree finds the neuron whose membrane potential is highest. The spike bit of that neuron, and not its potential, is sent to the next layer.

Window edge length, stride and frame width are inputs that are read at run time. A start-of-frame marker on the first beat of a timestep realigns the row and column counters. Beats with the valid input low are skipped. The storage the block needs is set by the largest frame width and the largest window. It does not grow with the number of timesteps.

Top module: `spk_maxpool`

## Requirements
- R1: During reset, and on the first cycle after reset is released, out_valid and out_spk are 0.
- R2: For each emitted window, out_spk equals the spike bit of the neuron with the largest membrane potential in that window. Potentials are compared as 16-bit two's-complement numbers, so -3 beats -50.
- R3: When several neurons in a window share the largest potential, the one that comes first in raster order wins. That is the topmost row first, then the leftmost column.
- R4: cfg_np gives the window edge length in neurons (binary 2 or 3). cfg_stride gives the step between windows (binary 1 or 2). All four combinations pool correctly, and this includes overlapping windows.
- R5: A window whose bottom-right neuron is at row r, column c (counted from 0) is emitted exactly when all of these hold: r >= Np-1, c >= Np-1, and both r-(Np-1) and c-(Np-1) are multiples of the stride. out_valid pulses for one cycle, two clock cycles after that neuron's beat is accepted. Windows come out in raster order of their bottom-right neuron.
- R6: cfg_width sets the frame width, from Np up to 32 neurons. A window never takes neurons from two different rows as if they were adjacent columns.
- R7: A beat with in_sof high is treated as row 0, column 0, whatever the counters held before.
- R8: Cycles with in_valid low do not change the counters or the window contents, and they produce no output. The values on in_pot, in_spk and in_sof during those cycles have no effect.
- R9: out_spk is 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier for the neuron stream |
| in_sof | input | 1 | High on the first neuron of a frame |
| in_pot | input | 16 | Signed membrane potential of the neuron |
| in_spk | input | 1 | Spike bit of the neuron in this timestep |
| cfg_width | input | 6 | Frame width in neurons |
| cfg_np | input | 2 | Window edge length (2 or 3) |
| cfg_stride | input | 2 | Window stride (1 or 2) |
| out_valid | output | 1 | One-cycle strobe per pooled window |
| out_spk | output | 1 | Spike bit of the window's winning neuron |

## Verification
The hardest case to reach is a window built from the delay chain taps at a width below the maximum while the stream has holes in it. Here a wrong tap index or a counter that advances on an idle beat gives the wrong neuron while the output timing still looks right. The stimulus covers this with frames from 3 to 32 columns wide, under every window and stride pairing, with random idle cycles that carry garbage data. Every pooled spike is also checked against the exact cycle it should appear in. Tie handling gets potentials drawn from a range of four values, plus frames where all potentials are equal and only the top-left neuron of each window spikes. Sign handling gets frames in which every potential is negative.

// File: rtl/spk_maxpool_pkg.sv
package spk_maxpool_pkg;
  localparam int POT_W = 16;

  typedef struct packed {
    logic                    spk;
    logic signed [POT_W-1:0] pot;
  } pix_t;

  typedef struct packed {
    logic                    vld;
    logic                    spk;
    logic signed [POT_W-1:0] pot;
  } cand_t;

  // Left operand is earlier in raster order and wins ties.
  function automatic cand_t pick(cand_t a, cand_t b);
    if (a.vld && (!b.vld || ($signed(a.pot) >= $signed(b.pot)))) return a;
    return b;
  endfunction

  function automatic logic pick_spk(cand_t a, cand_t b);
    if (a.vld && (!b.vld || ($signed(a.pot) >= $signed(b.pot)))) return a.spk;
    return b.vld & b.spk;
  endfunction
endpackage

// File: rtl/spk_mp_ctrl.sv
module spk_mp_ctrl #(
  parameter int MAX_W = 32,
  parameter int MAX_H = 32,
  parameter int WW    = $clog2(MAX_W + 1),
  parameter int NP_W  = 2,
  parameter int SW    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [WW-1:0]   cfg_width,
  input  logic [NP_W-1:0] cfg_np,
  input  logic [SW-1:0]   cfg_stride,
  output logic            emit
);
  localparam int CW = $clog2(MAX_W);
  localparam int RW = $clog2(MAX_H);

  logic [CW-1:0]   col_q, cur_col;
  logic [RW-1:0]   row_q, cur_row;
  logic [NP_W-1:0] np_m1;
  logic            last_col, unit_step, col_ok, row_ok;

  always_comb begin
    cur_col   = in_sof ? '0 : col_q;
    cur_row   = in_sof ? '0 : row_q;
    np_m1     = cfg_np - NP_W'(1);
    last_col  = (cur_col == CW'(cfg_width - WW'(1)));
    unit_step = (cfg_stride == SW'(1));
    col_ok    = (cur_col >= CW'(np_m1)) && (unit_step || (cur_col[0] == np_m1[0]));
    row_ok    = (cur_row >= RW'(np_m1)) && (unit_step || (cur_row[0] == np_m1[0]));
    emit      = in_valid && col_ok && row_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_valid) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= (cur_row == RW'(MAX_H - 1)) ? cur_row : cur_row + RW'(1);
      end else begin
        col_q <= cur_col + CW'(1);
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/spk_mp_linebuf.sv
module spk_mp_linebuf
  import spk_maxpool_pkg::*;
#(
  parameter int MAX_W   = 32,
  parameter int WIN_MAX = 3,
  parameter int WW      = $clog2(MAX_W + 1)
) (
  input  logic          clk,
  input  logic          in_valid,
  input  pix_t          din,
  input  logic [WW-1:0] cfg_width,
  output pix_t          col_in [WIN_MAX]
);
  localparam int DEPTH = (WIN_MAX - 1) * MAX_W;
  localparam int IW    = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  pix_t sr [DEPTH];

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  // sr[k] holds the beat accepted k+1 beats ago; row above = width beats ago.
  assign col_in[0] = din;
  for (genvar r = 1; r < WIN_MAX; r++) begin : g_tap
    assign col_in[r] = sr[IW'(r * int'(cfg_width) - 1)];
  end
endmodule

// File: rtl/spk_mp_window.sv
module spk_mp_window
  import spk_maxpool_pkg::*;
#(
  parameter int WIN_MAX = 3,
  parameter int NP_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            emit,
  input  logic [NP_W-1:0] cfg_np,
  input  pix_t            col_in [WIN_MAX],
  output pix_t            win [WIN_MAX][WIN_MAX],
  output logic            win_vld,
  output logic [NP_W-1:0] np_q
);
  // win[dr][dc]: neuron dr rows up and dc columns left of the newest beat.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int r = 0; r < WIN_MAX; r++) begin
        win[r][0] <= col_in[r];
        for (int c = 1; c < WIN_MAX; c++) win[r][c] <= win[r][c-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_vld <= 1'b0;
      np_q    <= NP_W'(2);
    end else begin
      win_vld <= emit;
      np_q    <= cfg_np;
    end
  end
endmodule

// File: rtl/spk_mp_argmax.sv
module spk_mp_argmax
  import spk_maxpool_pkg::*;
#(
  parameter int WIN_MAX = 3,
  parameter int NP_W    = 2
) (
  input  pix_t            win [WIN_MAX][WIN_MAX],
  input  logic [NP_W-1:0] np_q,
  output logic            o_spk
);
  localparam int LVLS   = $clog2(WIN_MAX * WIN_MAX);
  localparam int LEAVES = 1 << LVLS;

  cand_t by_n   [WIN_MAX+1][LEAVES];
  cand_t leaves [LEAVES];

  // Leaf k is raster position k of an n-by-n window (top-left first).
  for (genvar n = 0; n <= WIN_MAX; n++) begin : g_n
    for (genvar k = 0; k < LEAVES; k++) begin : g_k
      if (n >= 2 && k < n * n) begin : g_use
        localparam int DR = n - 1 - k / n;
        localparam int DC = n - 1 - k % n;
        assign by_n[n][k] = '{vld: 1'b1, spk: win[DR][DC].spk, pot: win[DR][DC].pot};
      end else begin : g_off
        assign by_n[n][k] = '0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LEAVES; k++) leaves[k] = by_n[np_q][k];
  end

  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    localparam int N = LEAVES >> lv;
    cand_t v [N];
    for (genvar k = 0; k < N; k++) begin : g_node
      if (lv == 0) begin : g_leaf
        assign v[k] = leaves[k];
      end else begin : g_merge
        assign v[k] = pick(g_lvl[lv-1].v[2*k], g_lvl[lv-1].v[2*k+1]);
      end
    end
  end

  assign o_spk = pick_spk(g_lvl[LVLS-1].v[0], g_lvl[LVLS-1].v[1]);
endmodule

// File: rtl/spk_maxpool.sv
module spk_maxpool
  import spk_maxpool_pkg::*;
#(
  parameter int MAX_W   = 32,
  parameter int MAX_H   = 32,
  parameter int WIN_MAX = 3,
  parameter int WW      = $clog2(MAX_W + 1),
  parameter int NP_W    = $clog2(WIN_MAX + 1),
  parameter int SW      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic signed [POT_W-1:0] in_pot,
  input  logic                    in_spk,
  input  logic [WW-1:0]           cfg_width,
  input  logic [NP_W-1:0]         cfg_np,
  input  logic [SW-1:0]           cfg_stride,
  output logic                    out_valid,
  output logic                    out_spk
);
  pix_t            din;
  pix_t            col_in [WIN_MAX];
  pix_t            win    [WIN_MAX][WIN_MAX];
  logic            emit, win_vld, win_spk;
  logic [NP_W-1:0] np_q;

  assign din = '{spk: in_spk, pot: in_pot};

  spk_mp_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H), .WW(WW), .NP_W(NP_W), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .cfg_width(cfg_width), .cfg_np(cfg_np), .cfg_stride(cfg_stride), .emit(emit)
  );

  spk_mp_linebuf #(.MAX_W(MAX_W), .WIN_MAX(WIN_MAX), .WW(WW)) u_lbuf (
    .clk(clk), .in_valid(in_valid), .din(din), .cfg_width(cfg_width), .col_in(col_in)
  );

  spk_mp_window #(.WIN_MAX(WIN_MAX), .NP_W(NP_W)) u_win (
    .clk(clk), .rst(rst), .in_valid(in_valid), .emit(emit), .cfg_np(cfg_np),
    .col_in(col_in), .win(win), .win_vld(win_vld), .np_q(np_q)
  );

  spk_mp_argmax #(.WIN_MAX(WIN_MAX), .NP_W(NP_W)) u_max (
    .win(win), .np_q(np_q), .o_spk(win_spk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_spk   <= 1'b0;
    end else begin
      out_valid <= win_vld;
      out_spk   <= win_vld & win_spk;
    end
  end
endmodule

// File: rtl/spk_maxpool_chk.sv
module spk_maxpool_chk #(
  parameter int NP_W = 2,
  parameter int SW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_sof,
  input logic [NP_W-1:0] cfg_np,
  input logic [SW-1:0]   cfg_stride,
  input logic            out_valid,
  input logic            out_spk
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !out_spk)); // R1

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((cfg_np == NP_W'(2) || cfg_np == NP_W'(3)) &&
                  (cfg_stride == SW'(1) || cfg_stride == SW'(2)))); // R4

  AST_OUT_FROM_BEAT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R5

  AST_SOF_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> ##1 !out_valid); // R7

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |=> !out_valid); // R8

  AST_SPK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_spk); // R9
endmodule

bind spk_maxpool spk_maxpool_chk #(.NP_W(NP_W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
  .cfg_np(cfg_np), .cfg_stride(cfg_stride), .out_valid(out_valid), .out_spk(out_spk)
);

// File: tb/spk_maxpool_tb.sv
module spk_maxpool_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {width[31:24], height[23:16], np[15:12], stride[11:8], mode[7:4], gaps[3:0]}
  // mode 0 full random, 1 narrow range (ties), 2 all equal, 3 all negative
  localparam logic [31:0] VEC [NV] = '{
    32'h08082200, 32'h08082100, 32'h09093110, 32'h0A073200, 32'h20202200,
    32'h05063230, 32'h06062220, 32'h07052111, 32'h03033100, 32'h20043201
  };

  logic clk = 1'b0;
  logic rst, in_valid, in_sof, in_spk, out_valid, out_spk;
  logic signed [15:0] in_pot;
  logic [5:0] cfg_width;
  logic [1:0] cfg_np, cfg_stride;

  int cyc = 0, checks = 0, errors = 0;
  int n_exp, n_got, idle_bad;
  logic signed [15:0] fp [32][32];
  bit fs [32][32];
  int exp_spk [2048], exp_cyc [2048], got_spk [2048], got_cyc [2048];

  spk_maxpool u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pot(in_pot),
    .in_spk(in_spk), .cfg_width(cfg_width), .cfg_np(cfg_np), .cfg_stride(cfg_stride),
    .out_valid(out_valid), .out_spk(out_spk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (n_got < 2048) begin
          got_spk[n_got] = int'(out_spk);
          got_cyc[n_got] = cyc;
        end
        n_got = n_got + 1;
      end else if (out_spk) idle_bad = idle_bad + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int ref_spk(int r, int c, int np);
    int br = r - np + 1, bc = c - np + 1;
    logic signed [15:0] best = fp[br][bc];
    int s = int'(fs[br][bc]);
    for (int i = 0; i < np; i++)
      for (int j = 0; j < np; j++)
        if (fp[br+i][bc+j] > best) begin
          best = fp[br+i][bc+j];
          s = int'(fs[br+i][bc+j]);
        end
    return s;
  endfunction

  task automatic idle_cyc();
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'($urandom);
    in_pot   = 16'($urandom);
    in_spk   = 1'($urandom);
  endtask

  task automatic run_frame(int w, int h, int np, int s, int mode, int gaps, string tag);
    cfg_width = 6'(w); cfg_np = 2'(np); cfg_stride = 2'(s);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        case (mode)
          1: fp[r][c] = 16'($urandom_range(3));
          2: fp[r][c] = 16'sd77;
          3: fp[r][c] = -16'($urandom_range(1000)) - 16'sd1;
          4: fp[r][c] = 16'sd100;
          default: fp[r][c] = 16'($urandom);
        endcase
        fs[r][c] = (mode == 4) ? ((r % 2 == 0) && (c % 2 == 0)) : 1'($urandom);
      end
    n_exp = 0; n_got = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (gaps != 0 && $urandom_range(2) == 0) begin
          idle_cyc();
          if ($urandom_range(1) == 0) idle_cyc();
        end
        @(negedge clk);
        in_valid = 1'b1; in_sof = (r == 0 && c == 0);
        in_pot = fp[r][c]; in_spk = fs[r][c];
        if (r >= np - 1 && c >= np - 1 && (r - np + 1) % s == 0 && (c - np + 1) % s == 0) begin
          exp_spk[n_exp] = ref_spk(r, c, np);
          exp_cyc[n_exp] = cyc + 2;
          n_exp++;
        end
      end
    repeat (4) idle_cyc();
    check(n_got == n_exp, "R4 R5 R6 window count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_spk[i] == exp_spk[i], tag, got_spk[i], exp_spk[i]);
      check(got_cyc[i] == exp_cyc[i], "R5 latency", got_cyc[i], exp_cyc[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    n_got = 0; n_exp = 0; idle_bad = 0;
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_pot = '0; in_spk = 1'b0;
    cfg_width = 6'd8; cfg_np = 2'd2; cfg_stride = 2'd2;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(out_spk == 1'b0, "R1 spike in reset", int'(out_spk), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

    for (int v = 0; v < NV; v++) begin
      int md = int'(VEC[v][7:4]);
      int gp = int'(VEC[v][3:0]);
      string tg = (gp != 0) ? "R8 spike" : (md == 1 || md == 2) ? "R3 spike" : "R2 spike";
      run_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:12]),
                int'(VEC[v][11:8]), md, gp, tg);
    end

    // R3: all potentials equal, only each window's top-left neuron spikes
    run_frame(6, 4, 2, 2, 4, 0, "R3 top-left tie");
    check(got_spk[0] == 1, "R3 first window", got_spk[0], 1);

    // R7: leave a frame half fed, then restart with in_sof
    cfg_width = 6'd8; cfg_np = 2'd2; cfg_stride = 2'd1; n_got = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_pot = 16'($urandom); in_spk = 1'b1;
    end
    repeat (3) idle_cyc();
    check(n_got == 0, "R7 partial row quiet", n_got, 0);
    run_frame(8, 5, 2, 1, 0, 0, "R7 realign");
    run_frame(5, 5, 3, 1, 3, 1, "R2 R8 negative gaps");

    check(idle_bad == 0, "R9 spike without valid", idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule